// File: doc/BRIEF.md
# Debug Link Register File

This block holds the sixteen 8-bit control and status registers of a debug and programming link controller. A host-side command decoder writes and reads them through a simple register-index port: a write strobe with an index and a data byte, and a read strobe with its own index whose data comes back one cycle later with a valid flag. Two single-cycle unlock pulses, produced elsewhere once a matching key has been received, raise the memory-programming enable and the debug enable. Software writes can only lower these enables.

The block drives three outputs toward the rest of the chip:

- a core reset request;
- a core halt request;
- the number of idle bits the physical layer inserts when the link changes direction.

A write of the hold key to the reset register either resets the core or, while debug is enabled, only halts it. A read-only debug state register reports which of the two holds is active. Indices with no function read as zero.

Top module: `dbg_csr_regs`

## Requirements
- R1: After reset every index reads 0x00, `core_reset_req` and `core_halt_req` are low, and `guard_bits` is 128.
- R2: A pulse on `unlock_nvm` sets status bit 1 and a pulse on `unlock_dbg` sets status bit 2 from the next cycle. A write to index 0 never sets either bit, and the other status bits always read 0.
- R3: Writing index 0 clears an enable whose data bit is 0 and leaves it unchanged when the bit is 1. If an unlock pulse arrives in the same cycle as a clearing write, the unlock wins.
- R4: While debug is disabled, writing 0x59 to index 1 raises `core_reset_req` from the next cycle. Writing any other value to index 1 drops both hold requests. Index 1 reads 0x01 while either hold is active and 0x00 otherwise.
- R5: While debug is enabled, writing 0x59 to index 1 raises `core_halt_req` and not `core_reset_req`. The two requests are never high together.
- R6: Clearing the debug enable drops `core_halt_req` on the following cycle.
- R7: Index 2 bits 2:0 select `guard_bits`: 0→128, 1→64, 2→32, 3→16, 4→8, 5→4, 6→2, 7→2.
- R8: Index 2 reads back its bits 2:0 with bits 7:3 as zero.
- R9: Index 3 is read-only. Bit 0 reports an active core reset hold and bit 1 an active halt, while debug is enabled. It reads 0x00 while debug is disabled.
- R10: Index 4 stores bit 0 of a write and reads it back, with bits 7:1 as zero.
- R11: Indices 5 to 15 read 0x00, and writes to them change no register.
- R12: `rd_valid` pulses exactly one cycle after `rd_en`. `rd_data` holds the register value from before any write made in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Index written |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 4 | Index read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data |
| unlock_nvm | input | 1 | Pulse that sets the memory-programming enable |
| unlock_dbg | input | 1 | Pulse that sets the debug enable |
| core_reset_req | output | 1 | Holds the core in reset |
| core_halt_req | output | 1 | Holds the core in halt |
| guard_bits | output | 8 | Idle bits inserted at a link turnaround |

## Verification
On every cycle the assertions check several properties:

- an enable rises only after an unlock pulse;
- reset and halt are never requested together;
- a halt ends once debug is disabled;
- the read response follows its strobe by one cycle, with reserved and gated indices reading zero.

Other behaviour can only be shown by the bench's scenarios. These are the full guard-time mapping, the choice of reset versus halt depending on the enable at write time, the same-cycle unlock/clear priority, and the read-before-write ordering. The same holds for the fact that writes to reserved indices and to the debug state register leave the other registers unchanged.

// File: rtl/dbg_csr_pkg.sv
package dbg_csr_pkg;
  localparam int CSR_DW    = 8;
  localparam int CSR_IDX_W = 4;
  localparam int GUARD_W   = 3;
  localparam int GUARD_MAX = 128;

  localparam int IDX_STATUS  = 0;
  localparam int IDX_RESET   = 1;
  localparam int IDX_CTRL    = 2;
  localparam int IDX_DSTATE  = 3;
  localparam int IDX_DENABLE = 4;

  localparam int BIT_NVM   = 1;
  localparam int BIT_DBG   = 2;
  localparam int BIT_RST   = 0;
  localparam int BIT_PAUSE = 1;

  localparam logic [7:0] CORE_HOLD_KEY = 8'h59;

  typedef struct packed {
    logic nvm;
    logic dbg;
  } en_t;
endpackage

// File: rtl/dbg_csr_enables.sv
module dbg_csr_enables
  import dbg_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_st,
  input  logic wr_nvm_bit,
  input  logic wr_dbg_bit,
  input  logic unlock_nvm,
  input  logic unlock_dbg,
  output en_t  en_q
);
  en_t  en_d;
  logic en_upd;

  assign en_upd = wr_st | unlock_nvm | unlock_dbg;

  always_comb begin
    en_d = en_q;
    if (wr_st) begin
      en_d.nvm = en_q.nvm & wr_nvm_bit;
      en_d.dbg = en_q.dbg & wr_dbg_bit;
    end
    if (unlock_nvm) en_d.nvm = 1'b1;
    if (unlock_dbg) en_d.dbg = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  // R2
  nvm_only_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q.nvm) |-> $past(unlock_nvm));
  // R2
  dbg_only_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q.dbg) |-> $past(unlock_dbg));
  // R3
  dbg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_st && !wr_dbg_bit && !unlock_dbg) |-> !en_q.dbg);
endmodule

// File: rtl/dbg_csr_core_hold.sv
module dbg_csr_core_hold
  import dbg_csr_pkg::*;
#(
  parameter int DATA_W = CSR_DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_en,
  output logic              rst_hold_q,
  output logic              halt_hold_q
);
  localparam logic [DATA_W-1:0] HOLD_KEY = DATA_W'(CORE_HOLD_KEY);

  logic rst_hold_d, halt_hold_d, key_hit, hold_upd;

  assign key_hit  = (wr_data == HOLD_KEY);
  assign hold_upd = wr_rst | (halt_hold_q & ~dbg_en);

  always_comb begin
    rst_hold_d  = rst_hold_q;
    halt_hold_d = halt_hold_q;
    if (wr_rst) begin
      rst_hold_d  = key_hit & ~dbg_en;
      halt_hold_d = key_hit &  dbg_en;
    end
    if (!dbg_en) halt_hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_hold_q  <= 1'b0;
      halt_hold_q <= 1'b0;
    end else if (hold_upd) begin
      rst_hold_q  <= rst_hold_d;
      halt_hold_q <= halt_hold_d;
    end
  end

  // R5
  hold_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_hold_q && halt_hold_q));
  // R6
  halt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbg_en) |=> !halt_hold_q);
  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_rst && (wr_data != HOLD_KEY)) |-> (!rst_hold_q && !halt_hold_q));
endmodule

// File: rtl/dbg_csr_guard.sv
module dbg_csr_guard
  import dbg_csr_pkg::*;
#(
  parameter int SEL_W    = GUARD_W,
  parameter int MAX_BITS = GUARD_MAX
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_ctl,
  input  logic [SEL_W-1:0]               wr_sel,
  output logic [SEL_W-1:0]               sel_q,
  output logic [$clog2(MAX_BITS):0]      guard_bits
);
  localparam int OUT_W = $clog2(MAX_BITS) + 1;
  localparam int SAT   = $clog2(MAX_BITS) - 1;

  logic [SEL_W-1:0] sel_d;
  logic [SEL_W-1:0] shift;

  always_comb begin
    sel_d = sel_q;
    if (wr_ctl) sel_d = wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_ctl) sel_q <= sel_d;
  end

  assign shift      = (sel_q > SEL_W'(SAT)) ? SEL_W'(SAT) : sel_q;
  assign guard_bits = OUT_W'(MAX_BITS) >> shift;

  // R7
  guard_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctl && (wr_sel == '0)) |-> (guard_bits == OUT_W'(MAX_BITS)));
endmodule

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_csr_pkg::*;
#(
  parameter int DATA_W    = CSR_DW,
  parameter int IDX_W     = CSR_IDX_W,
  parameter int SEL_W     = GUARD_W,
  parameter int MAX_GUARD = GUARD_MAX
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_en,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          unlock_nvm,
  input  logic                          unlock_dbg,
  output logic                          core_reset_req,
  output logic                          core_halt_req,
  output logic [$clog2(MAX_GUARD):0]    guard_bits
);
  localparam int NUM_REGS = 1 << IDX_W;

  logic [NUM_REGS-1:0] wr_sel;
  en_t                 en_q;
  logic                rst_hold_q, halt_hold_q;
  logic [SEL_W-1:0]    gsel_q;
  logic                eng_on_q, eng_on_d;
  logic [DATA_W-1:0]   stat_rd, rst_rd, ctl_rd, dst_rd, den_rd;
  logic [DATA_W-1:0]   rd_vec [NUM_REGS];
  logic [DATA_W-1:0]   rd_data_d;

  assign wr_sel = wr_en ? (NUM_REGS'(1) << wr_idx) : '0;

  dbg_csr_enables u_enables (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_st      (wr_sel[IDX_STATUS]),
    .wr_nvm_bit (wr_data[BIT_NVM]),
    .wr_dbg_bit (wr_data[BIT_DBG]),
    .unlock_nvm (unlock_nvm),
    .unlock_dbg (unlock_dbg),
    .en_q       (en_q)
  );

  dbg_csr_core_hold #(.DATA_W(DATA_W)) u_core_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_rst      (wr_sel[IDX_RESET]),
    .wr_data     (wr_data),
    .dbg_en      (en_q.dbg),
    .rst_hold_q  (rst_hold_q),
    .halt_hold_q (halt_hold_q)
  );

  dbg_csr_guard #(.SEL_W(SEL_W), .MAX_BITS(MAX_GUARD)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctl     (wr_sel[IDX_CTRL]),
    .wr_sel     (wr_data[SEL_W-1:0]),
    .sel_q      (gsel_q),
    .guard_bits (guard_bits)
  );

  always_comb begin
    eng_on_d = eng_on_q;
    if (wr_sel[IDX_DENABLE]) eng_on_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   eng_on_q <= 1'b0;
    else if (wr_sel[IDX_DENABLE]) eng_on_q <= eng_on_d;
  end

  assign core_reset_req = rst_hold_q;
  assign core_halt_req  = halt_hold_q;

  always_comb begin
    stat_rd          = '0;
    stat_rd[BIT_NVM] = en_q.nvm;
    stat_rd[BIT_DBG] = en_q.dbg;
    rst_rd           = '0;
    rst_rd[0]        = rst_hold_q | halt_hold_q;
    ctl_rd           = '0;
    ctl_rd[SEL_W-1:0] = gsel_q;
    dst_rd           = '0;
    dst_rd[BIT_RST]   = en_q.dbg & rst_hold_q;
    dst_rd[BIT_PAUSE] = en_q.dbg & halt_hold_q;
    den_rd           = '0;
    den_rd[0]        = eng_on_q;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_rd
    if (i == IDX_STATUS)       begin : g_st  assign rd_vec[i] = stat_rd; end
    else if (i == IDX_RESET)   begin : g_rs  assign rd_vec[i] = rst_rd;  end
    else if (i == IDX_CTRL)    begin : g_ct  assign rd_vec[i] = ctl_rd;  end
    else if (i == IDX_DSTATE)  begin : g_ds  assign rd_vec[i] = dst_rd;  end
    else if (i == IDX_DENABLE) begin : g_de  assign rd_vec[i] = den_rd;  end
    else                       begin : g_rv  assign rd_vec[i] = '0;      end
  end

  assign rd_data_d = rd_vec[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_valid <= 1'b0;
    else            rd_valid <= rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_data_d;
  end

  // R12
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R12
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en));
  // R9
  dstate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && (rd_idx == IDX_W'(IDX_DSTATE)) && !en_q.dbg) |-> (rd_data == '0));
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && (rd_idx > IDX_W'(IDX_DENABLE))) |-> (rd_data == '0));
endmodule

// File: tb/test_dbg_csr_regs.sv
module test_dbg_csr_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, unlock_nvm, unlock_dbg;
  logic [3:0] wr_idx, rd_idx;
  logic [7:0] wr_data;
  logic       rd_valid, core_reset_req, core_halt_req;
  logic [7:0] rd_data, guard_bits;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  dbg_csr_regs i_dbg_csr_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .unlock_nvm(unlock_nvm), .unlock_dbg(unlock_dbg),
    .core_reset_req(core_reset_req), .core_halt_req(core_halt_req),
    .guard_bits(guard_bits)
  );

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected read results as they come out
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R12 actual=unexpected_read expected=none");
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; rd_idx = idx;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input bit nvm, input bit dbg);
    @(negedge clk); unlock_nvm = nvm; unlock_dbg = dbg;
    @(negedge clk); unlock_nvm = 1'b0; unlock_dbg = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; unlock_nvm = 0; unlock_dbg = 0;
    wr_idx = 0; rd_idx = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 reset_req", core_reset_req, 0);
    chk("R1 halt_req", core_halt_req, 0);
    chk("R1 guard", guard_bits, 128);
    for (int i = 0; i < 16; i++) rd(4'(i), 8'h00, "R1 read");

    // R2 unlock sets, writes never set
    wr(0, 8'hFF);          rd(0, 8'h00, "R2 sw_no_set");
    pulse(1, 0);           rd(0, 8'h02, "R2 nvm_unlock");
    pulse(0, 1);           rd(0, 8'h06, "R2 dbg_unlock");

    // R3 clear with 0, keep with 1, unlock wins
    wr(0, 8'hFB);          rd(0, 8'h02, "R3 clear_dbg");
    wr(0, 8'hFF);          rd(0, 8'h02, "R3 keep");
    @(negedge clk); wr_en = 1; wr_idx = 0; wr_data = 8'h00; unlock_dbg = 1;
    @(negedge clk); wr_en = 0; unlock_dbg = 0;
    rd(0, 8'h04, "R3 unlock_wins");
    wr(0, 8'h00);          rd(0, 8'h00, "R3 clear_all");

    // R4 reset hold with debug disabled
    wr(1, 8'h59);
    chk("R4 reset_req", core_reset_req, 1);
    chk("R4 no_halt", core_halt_req, 0);
    rd(1, 8'h01, "R4 read_hold");
    rd(3, 8'h00, "R9 gated");
    wr(1, 8'h00);
    chk("R4 release", core_reset_req, 0);
    rd(1, 8'h00, "R4 read_free");
    wr(1, 8'h58);
    chk("R4 near_key", core_reset_req, 0);

    // R5 halt with debug enabled
    pulse(0, 1);
    wr(1, 8'h59);
    chk("R5 halt_req", core_halt_req, 1);
    chk("R5 no_reset", core_reset_req, 0);
    rd(3, 8'h02, "R9 pause_bit");
    wr(3, 8'hFF);
    rd(3, 8'h02, "R9 ro");
    chk("R9 ro_halt", core_halt_req, 1);
    wr(1, 8'h12);
    chk("R5 resume", core_halt_req, 0);

    // R6 disabling debug drops halt
    wr(1, 8'h59);
    chk("R6 halted", core_halt_req, 1);
    wr(0, 8'h00);
    @(negedge clk);
    chk("R6 halt_drop", core_halt_req, 0);
    chk("R6 no_reset", core_reset_req, 0);
    rd(3, 8'h00, "R9 off");

    // R9 reset bit visible when debug enabled later
    wr(1, 8'h59);
    pulse(0, 1);
    chk("R9 reset_kept", core_reset_req, 1);
    rd(3, 8'h01, "R9 reset_bit");
    wr(1, 8'h00);

    // R7 / R8 guard mapping
    for (int g = 0; g < 8; g++) begin
      wr(2, 8'hF8 | 8'(g));
      chk("R7 guard", guard_bits, 128 >> ((g > 6) ? 6 : g));
      rd(2, 8'(g), "R8 ctl_read");
    end

    // R10 debug enable register
    wr(4, 8'hFF);          rd(4, 8'h01, "R10 set");
    wr(4, 8'hFE);          rd(4, 8'h00, "R10 clear");
    wr(4, 8'h01);

    // R11 reserved indices
    for (int i = 5; i < 16; i++) begin
      wr(4'(i), 8'hFF);
      rd(4'(i), 8'h00, "R11 reserved");
    end
    rd(2, 8'h07, "R11 ctl_kept");
    rd(4, 8'h01, "R11 den_kept");
    rd(0, 8'h04, "R11 stat_kept");
    rd(1, 8'h00, "R11 rst_kept");
    chk("R11 guard_kept", guard_bits, 2);

    // R12 read before same-cycle write
    @(negedge clk); wr_en = 1; wr_idx = 2; wr_data = 8'h03; rd_en = 1; rd_idx = 2;
    exp_q.push_back(8'h07); tag_q.push_back("R12 old_value");
    @(negedge clk); wr_en = 0; rd_en = 0;
    rd(2, 8'h03, "R12 new_value");
    chk("R12 guard", guard_bits, 16);

    // R1 reset mid-run
    wr(1, 8'h00);
    do_reset();
    chk("R1 guard_rst", guard_bits, 128);
    chk("R1 halt_rst", core_halt_req, 0);
    rd(0, 8'h00, "R1 stat_rst");
    rd(4, 8'h00, "R1 den_rst");
    rd(2, 8'h00, "R1 ctl_rst");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R12 actual=%0d expected=0 pending reads", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule